// File: doc/BRIEF.md
# Shadowed Greater-or-Equal Compare Cell with Pulse Count Modulation

This block is the last cell of a chain of local timer cells. It does not count. It watches the timer value that its lower-numbered neighbour places on a shared bus, together with a strobe that marks each cycle in which that value changed. In every strobed cycle it tests whether the timer is greater than or equal to its compare operand. On a match it drives an output line according to a programmable action and can pulse a service request. When bit reversal is on, the timer is mirrored (bit 0 swapped with the top bit, and so on) before the test. A linear ramp then becomes a pulse count modulated waveform, in which the high time is spread over the whole period instead of forming one block.

The compare operand can be replaced in hardware. A shadow register holds the next operand. A rising edge on one selectable trigger input copies the shadow into the compare register and can pulse a second service request. A small state machine guards this switching function. Its three states are SW_OFF (disabled), SW_ARMED (waiting for an edge) and SW_SPENT (one-shot already used). Its transitions are: a control write with the switch enabled goes to SW_ARMED, from any state; a control write with the switch disabled goes to SW_OFF, from any state; a trigger edge in SW_ARMED with one-shot set goes to SW_SPENT; a trigger edge in SW_ARMED without one-shot stays in SW_ARMED. SW_OFF and SW_SPENT leave only on a control write. Software loads the registers and the control fields through plain write-enable ports.

Top module: `shadow_cmp_cell`

## Requirements
- R1: A synchronous reset clears the compare register, the shadow register, the output line and both request outputs. It also sets the action to hold, turns bit reversal off, and puts the switching function in SW_OFF.
- R2: In a cycle with `tmr_upd` high and the operand greater than or equal to the compare value, the block raises `cmp_req` for exactly one cycle on the next clock, provided `ctl_cmp_req_en` is 1. With the enable at 0 no request is raised, but the output action still takes place.
- R3: In a cycle with `tmr_upd` low, no compare event occurs, whatever the timer value is. `out_line` keeps its value and `cmp_req` stays low.
- R4: On a compare event, `out_line` is updated on the next clock according to `ctl_act`: 0 holds the line, 1 sets it, 2 clears it, 3 toggles it.
- R5: With `ctl_rev` at 1, the operand is the timer value with bit i moved to bit TW-1-i, and this mirrored value is compared against the compare register.
- R6: In SW_ARMED, a 0-to-1 change of `trig_in[ctl_tsel]` between two consecutive cycles copies the shadow register into the compare register on that clock. Edges on unselected inputs have no effect, and a trigger held high does not switch again.
- R7: A switching event pulses `sw_req` for one cycle if `ctl_sw_req_en` is 1. With the enable at 0, the copy still happens but no request is raised.
- R8: With `ctl_one` at 1, the first switching event moves the function to SW_SPENT, and later edges are ignored. A control write with `ctl_sw_en` at 1 re-arms the function.
- R9: A compare event and a switching event in the same cycle are both reported. The comparison in that cycle uses the old compare value, and the shadow value takes effect from the next cycle.
- R10: When a switching event and a software write to the compare register fall in the same cycle, the shadow value wins.
- R11: `cmp_val` always shows the compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_val | input | TW | Timer value from the neighbouring cell |
| tmr_upd | input | 1 | Marks a cycle in which tmr_val was updated |
| trig_in | input | NTRIG | Candidate trigger lines for compare value switching |
| cmp_wr | input | 1 | Write strobe for the compare register |
| cmp_wdata | input | TW | Compare register write data |
| shd_wr | input | 1 | Write strobe for the shadow register |
| shd_wdata | input | TW | Shadow register write data |
| ctl_wr | input | 1 | Write strobe for all control fields |
| ctl_act | input | 2 | Output action: 0 hold, 1 set, 2 clear, 3 toggle |
| ctl_rev | input | 1 | Bit reversal (pulse count modulation) enable |
| ctl_sw_en | input | 1 | Compare value switching enable (arms the function) |
| ctl_one | input | 1 | One-shot switching |
| ctl_cmp_req_en | input | 1 | Compare service request enable |
| ctl_sw_req_en | input | 1 | Switching service request enable |
| ctl_tsel | input | TSELW | Index of the trigger line in trig_in |
| out_line | output | 1 | Output line driven by compare events |
| cmp_req | output | 1 | Compare service request pulse |
| sw_req | output | 1 | Switching service request pulse |
| cmp_val | output | TW | Current compare register value |

## Verification
The bench builds the cell with a 4-bit timer and two trigger lines. At that width it can walk every compare value against every timer value, both plain and mirrored, with the toggle action on. Each request and each output flip in this sweep is predicted by arithmetic in the bench. With two trigger lines, an edge on the unselected line can be shown to have no effect. The remaining sequences cover switching, one-shot re-arming, stalls and same-cycle collisions, using chosen values.

// File: rtl/scc_pkg.sv
package scc_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TOG  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        SW_OFF   = 2'd0,
        SW_ARMED = 2'd1,
        SW_SPENT = 2'd2
    } sw_state_e;

endpackage

// File: rtl/scc_operand.sv
module scc_operand #(
    parameter int TW = 16
) (
    input  logic [TW-1:0] tmr,
    input  logic          rev_en,
    output logic [TW-1:0] opnd
);

    logic [TW-1:0] mirrored;

    for (genvar i = 0; i < TW; i++) begin : g_mirror
        assign mirrored[i] = tmr[TW-1-i];
    end

    assign opnd = rev_en ? mirrored : tmr;

endmodule

// File: rtl/scc_compare.sv
module scc_compare
    import scc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] opnd,
    input  logic          upd,
    input  logic [TW-1:0] cmp,
    input  act_e          act,
    input  logic          req_en,
    output logic          out_line,
    output logic          req
);

    logic hit;
    logic out_q, out_d;
    logic req_q;

    assign hit = upd && (opnd >= cmp);

    always_comb begin
        out_d = out_q;
        if (hit) begin
            unique case (act)
                ACT_HOLD: out_d = out_q;
                ACT_SET:  out_d = 1'b1;
                ACT_CLR:  out_d = 1'b0;
                ACT_TOG:  out_d = ~out_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            out_q <= out_d;
            req_q <= hit && req_en;
        end
    end

    assign out_line = out_q;
    assign req      = req_q;

    a_r2_req_needs_update: assert property (@(posedge clk) disable iff (rst)
        req_q |-> $past(upd));
    a_r3_stall_holds_out: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(out_q));
    a_r4_set_drives_high: assert property (@(posedge clk) disable iff (rst)
        (upd && opnd >= cmp && act == ACT_SET) |=> out_q);
    a_r4_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (upd && opnd >= cmp && act == ACT_TOG) |=> (out_q != $past(out_q)));

endmodule

// File: rtl/scc_switch.sv
module scc_switch
    import scc_pkg::*;
#(
    parameter  int NTRIG = 4,
    localparam int TSELW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTRIG-1:0] trig,
    input  logic [TSELW-1:0] tsel,
    input  logic             one_shot,
    input  logic             req_en,
    input  logic             ctl_wr,
    input  logic             new_en,
    output logic             fire,
    output logic             req
);

    sw_state_e        st_q, st_d;
    logic [NTRIG-1:0] trig_prev;
    logic             sel_ok, cur, prev, rise;
    logic             req_q;

    assign sel_ok = (int'(tsel) < NTRIG);
    assign cur    = sel_ok ? trig[tsel]      : 1'b0;
    assign prev   = sel_ok ? trig_prev[tsel] : 1'b0;
    assign rise   = cur && !prev;
    assign fire   = (st_q == SW_ARMED) && rise;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SW_OFF:   st_d = SW_OFF;
            SW_ARMED: if (rise && one_shot) st_d = SW_SPENT;
            SW_SPENT: st_d = SW_SPENT;
            default:  st_d = SW_OFF;
        endcase
        if (ctl_wr) st_d = new_en ? SW_ARMED : SW_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= SW_OFF;
            trig_prev <= '0;
        end else begin
            st_q      <= st_d;
            trig_prev <= trig;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= fire && req_en;
    end

    assign req = req_q;

    a_r7_req_follows_switch: assert property (@(posedge clk) disable iff (rst)
        req_q |-> $past(fire));
    a_r8_spent_never_fires: assert property (@(posedge clk) disable iff (rst)
        (st_q == SW_SPENT) |-> !fire);
    a_r8_oneshot_disarms: assert property (@(posedge clk) disable iff (rst)
        (fire && one_shot && !ctl_wr) |=> (st_q == SW_SPENT));

endmodule

// File: rtl/shadow_cmp_cell.sv
module shadow_cmp_cell
    import scc_pkg::*;
#(
    parameter  int TW    = 16,
    parameter  int NTRIG = 4,
    localparam int TSELW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TW-1:0]    tmr_val,
    input  logic             tmr_upd,
    input  logic [NTRIG-1:0] trig_in,
    input  logic             cmp_wr,
    input  logic [TW-1:0]    cmp_wdata,
    input  logic             shd_wr,
    input  logic [TW-1:0]    shd_wdata,
    input  logic             ctl_wr,
    input  logic [1:0]       ctl_act,
    input  logic             ctl_rev,
    input  logic             ctl_sw_en,
    input  logic             ctl_one,
    input  logic             ctl_cmp_req_en,
    input  logic             ctl_sw_req_en,
    input  logic [TSELW-1:0] ctl_tsel,
    output logic             out_line,
    output logic             cmp_req,
    output logic             sw_req,
    output logic [TW-1:0]    cmp_val
);

    logic [TW-1:0]    cmp_q, shd_q, opnd;
    act_e             act_q;
    logic             rev_q, one_q, creq_en_q, sreq_en_q;
    logic [TSELW-1:0] tsel_q;
    logic             sw_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= ACT_HOLD;
            rev_q     <= 1'b0;
            one_q     <= 1'b0;
            creq_en_q <= 1'b0;
            sreq_en_q <= 1'b0;
            tsel_q    <= '0;
        end else if (ctl_wr) begin
            act_q     <= act_e'(ctl_act);
            rev_q     <= ctl_rev;
            one_q     <= ctl_one;
            creq_en_q <= ctl_cmp_req_en;
            sreq_en_q <= ctl_sw_req_en;
            tsel_q    <= ctl_tsel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= '0;
        else if (sw_fire) cmp_q <= shd_q;
        else if (cmp_wr)  cmp_q <= cmp_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)         shd_q <= '0;
        else if (shd_wr) shd_q <= shd_wdata;
    end

    scc_operand #(.TW(TW)) u_operand (
        .tmr    (tmr_val),
        .rev_en (rev_q),
        .opnd   (opnd)
    );

    scc_compare #(.TW(TW)) u_compare (
        .clk      (clk),
        .rst      (rst),
        .opnd     (opnd),
        .upd      (tmr_upd),
        .cmp      (cmp_q),
        .act      (act_q),
        .req_en   (creq_en_q),
        .out_line (out_line),
        .req      (cmp_req)
    );

    scc_switch #(.NTRIG(NTRIG)) u_switch (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig_in),
        .tsel     (tsel_q),
        .one_shot (one_q),
        .req_en   (sreq_en_q),
        .ctl_wr   (ctl_wr),
        .new_en   (ctl_sw_en),
        .fire     (sw_fire),
        .req      (sw_req)
    );

    assign cmp_val = cmp_q;

    a_r6_switch_loads_shadow: assert property (@(posedge clk) disable iff (rst)
        sw_fire |=> (cmp_q == $past(shd_q)));
    a_r10_switch_beats_write: assert property (@(posedge clk) disable iff (rst)
        (sw_fire && cmp_wr) |=> (cmp_q != $past(cmp_wdata) || $past(shd_q) == $past(cmp_wdata)));
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cmp_q == '0 && shd_q == '0 && !out_line));

endmodule

// File: tb/test_shadow_cmp_cell.sv
`timescale 1ns/1ps
module test_shadow_cmp_cell;

    localparam int TW = 4;
    localparam int NTRIG = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [TW-1:0] tmr_val = '0;
    logic tmr_upd = 1'b0;
    logic [NTRIG-1:0] trig_in = '0;
    logic cmp_wr = 1'b0, shd_wr = 1'b0, ctl_wr = 1'b0;
    logic [TW-1:0] cmp_wdata = '0, shd_wdata = '0;
    logic [1:0] ctl_act = 2'd0;
    logic ctl_rev = 1'b0, ctl_sw_en = 1'b0, ctl_one = 1'b0;
    logic ctl_cmp_req_en = 1'b0, ctl_sw_req_en = 1'b0;
    logic [0:0] ctl_tsel = 1'b0;
    logic out_line, cmp_req, sw_req;
    logic [TW-1:0] cmp_val;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    shadow_cmp_cell #(.TW(TW), .NTRIG(NTRIG)) i_shadow_cmp_cell (
        .clk(clk), .rst(rst), .tmr_val(tmr_val), .tmr_upd(tmr_upd),
        .trig_in(trig_in), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .shd_wr(shd_wr), .shd_wdata(shd_wdata), .ctl_wr(ctl_wr),
        .ctl_act(ctl_act), .ctl_rev(ctl_rev), .ctl_sw_en(ctl_sw_en),
        .ctl_one(ctl_one), .ctl_cmp_req_en(ctl_cmp_req_en),
        .ctl_sw_req_en(ctl_sw_req_en), .ctl_tsel(ctl_tsel),
        .out_line(out_line), .cmp_req(cmp_req), .sw_req(sw_req),
        .cmp_val(cmp_val)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mirror(input int v);
        int r = 0;
        for (int i = 0; i < TW; i++) if (v[i]) r |= (1 << (TW-1-i));
        return r;
    endfunction

    task automatic wr_cmp(input int v);
        cmp_wr = 1'b1; cmp_wdata = TW'(v);
        @(negedge clk);
        cmp_wr = 1'b0;
    endtask

    task automatic wr_shd(input int v);
        shd_wr = 1'b1; shd_wdata = TW'(v);
        @(negedge clk);
        shd_wr = 1'b0;
    endtask

    task automatic wr_ctl(input int act, input bit rev, input bit swen, input bit one,
                          input bit creq, input bit sreq, input bit tsel);
        ctl_wr = 1'b1; ctl_act = 2'(act); ctl_rev = rev; ctl_sw_en = swen;
        ctl_one = one; ctl_cmp_req_en = creq; ctl_sw_req_en = sreq; ctl_tsel = tsel;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic pulse_trig(input logic [NTRIG-1:0] v);
        trig_in = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int exp_out;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 out", out_line, 0);
        chk("R1 cmp_val", cmp_val, 0);
        chk("R1 cmp_req", cmp_req, 0);
        chk("R1 sw_req", sw_req, 0);

        // R2 R4 R5: full sweep with toggle action, plain and mirrored
        exp_out = 0;
        for (int rv = 0; rv < 2; rv++) begin
            wr_ctl(3, rv[0], 0, 0, 1, 0, 0);
            for (int c = 0; c < (1 << TW); c++) begin
                wr_cmp(c);
                for (int t = 0; t < (1 << TW); t++) begin
                    int op;
                    bit hit;
                    op = (rv != 0) ? mirror(t) : t;
                    hit = (op >= c);
                    tmr_val = TW'(t); tmr_upd = 1'b1;
                    @(negedge clk);
                    if (hit) exp_out ^= 1;
                    chk(rv != 0 ? "R5 mirrored req" : "R2 ge req", cmp_req, int'(hit));
                    chk("R4 toggle", out_line, exp_out);
                end
                tmr_upd = 1'b0;
            end
        end

        // R3: stalled timer, output and request quiet
        wr_ctl(1, 0, 0, 0, 1, 0, 0);
        wr_cmp(0);
        tmr_val = 4'hF; tmr_upd = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R3 out steady", out_line, exp_out);
        chk("R3 no req", cmp_req, 0);
        wr_ctl(2, 0, 0, 0, 1, 0, 0);
        tmr_upd = 1'b1;
        @(negedge clk);
        tmr_upd = 1'b0;
        chk("R4 clear", out_line, 0);
        wr_ctl(1, 0, 0, 0, 0, 0, 0);
        tmr_upd = 1'b1;
        @(negedge clk);
        tmr_upd = 1'b0;
        chk("R4 set", out_line, 1);
        chk("R2 req disabled", cmp_req, 0);
        wr_ctl(0, 0, 0, 0, 1, 0, 0);
        tmr_upd = 1'b1;
        @(negedge clk);
        tmr_upd = 1'b0;
        chk("R4 hold", out_line, 1);
        chk("R2 req with hold", cmp_req, 1);

        // R6 R7 R11: switching on selected line 1, repeat mode
        wr_shd(9); wr_cmp(3);
        wr_ctl(0, 0, 1, 0, 0, 1, 1);
        chk("R11 cmp_val", cmp_val, 3);
        pulse_trig(2'b10);
        chk("R6 switched", cmp_val, 9);
        chk("R7 sw_req", sw_req, 1);
        pulse_trig(2'b10);
        chk("R6 level no repeat", sw_req, 0);
        wr_shd(12);
        pulse_trig(2'b01);
        chk("R6 unselected ignored", cmp_val, 9);
        chk("R6 unselected no req", sw_req, 0);
        pulse_trig(2'b00);
        pulse_trig(2'b10);
        chk("R6 second edge", cmp_val, 12);
        pulse_trig(2'b00);

        // R8: one-shot
        wr_shd(5);
        wr_ctl(0, 0, 1, 1, 0, 1, 1);
        pulse_trig(2'b10);
        chk("R8 first edge", cmp_val, 5);
        pulse_trig(2'b00);
        wr_shd(7);
        pulse_trig(2'b10);
        chk("R8 spent value", cmp_val, 5);
        chk("R8 spent no req", sw_req, 0);
        pulse_trig(2'b00);
        wr_ctl(0, 0, 1, 1, 0, 1, 1);
        pulse_trig(2'b10);
        chk("R8 rearmed", cmp_val, 7);
        pulse_trig(2'b00);

        // R7: request disabled, copy still happens
        wr_shd(2);
        wr_ctl(0, 0, 1, 0, 1, 0, 1);
        pulse_trig(2'b10);
        chk("R7 copy without req", cmp_val, 2);
        chk("R7 no sw_req", sw_req, 0);
        pulse_trig(2'b00);

        // R9: same-cycle compare and switch
        wr_cmp(5); wr_shd(10);
        wr_ctl(2, 0, 1, 0, 1, 1, 1);
        tmr_upd = 1'b1; tmr_val = 4'd7;
        @(negedge clk);
        wr_ctl(1, 0, 1, 0, 1, 1, 1);
        tmr_val = 4'd7; tmr_upd = 1'b1; trig_in = 2'b10;
        @(negedge clk);
        chk("R9 cmp_req old value", cmp_req, 1);
        chk("R9 sw_req", sw_req, 1);
        chk("R9 out set", out_line, 1);
        chk("R9 new value", cmp_val, 10);
        @(negedge clk);
        chk("R9 new value used", cmp_req, 0);
        tmr_upd = 1'b0; trig_in = 2'b00;
        @(negedge clk);

        // R10: switch beats software write
        wr_shd(3);
        cmp_wr = 1'b1; cmp_wdata = 4'd8; trig_in = 2'b10;
        @(negedge clk);
        cmp_wr = 1'b0; trig_in = 2'b00;
        chk("R10 shadow wins", cmp_val, 3);

        // R1: reset mid-run disables switching
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset out", out_line, 0);
        chk("R1 reset cmp", cmp_val, 0);
        wr_shd(6);
        pulse_trig(2'b01);
        pulse_trig(2'b00);
        chk("R1 switch off after reset", cmp_val, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule